// File: doc/BRIEF.md
# Cache line invalidate execution unit

This unit carries out the privileged instruction that discards one line of a small data cache. It recognises the instruction from a 32-bit word, names the two general-purpose registers it needs on the register-file read ports, and adds their values to form the effective address. It then screens the access against the current mode, the address-translation answer and the page protection attributes. The result is either exactly one exception with a cause code, or the invalidation of the matching line in the 64-line direct-mapped tag array that the unit holds.

The instruction is treated as a store for protection and for the debug address comparator. The line is discarded whether or not it holds modified data, and nothing is written back. The unit never writes a general-purpose register. A refill path installs lines through a tag-install port. A lookup port lets the load/store side read the valid and modified state of any line address. Translation contents live outside the unit and answer a lookup request within the same cycle.

Top module: `line_inval_unit`

## Requirements
- R1: An instruction word is accepted only when word bits [31:26] equal 31, bits [25:21] are zero, bits [10:1] equal 470 and bit [0] is zero. Bits [20:16] select the base register and bits [15:11] select the index register. Any other word produces no done strobe and changes no line.
- R2: The effective address is the index register value plus a base, modulo 2^32. The base is zero when the base-register field is 0 and the base register's value otherwise.
- R3: When no exception is raised and the address matches a valid line, that line becomes invalid and `inval_hit` is 1 together with `done`. The line is selected by address bits [10:5] and matched on bits [31:11].
- R4: A line holding modified data is invalidated in the same way, and its modified flag reads 0 afterwards.
- R5: When the address matches no valid line, `done` rises with `inval_hit` 0 and no exception, and no line changes state.
- R6: With `user_mode` 1, the result is cause 2'b01 (program) and no line is invalidated.
- R7: With `reloc_en` 1 and `tlb_hit` 0, the result is cause 2'b10 (translation miss). With `reloc_en` 0, the translation answer and the zone are ignored.
- R8: Zone codes on `tlb_zone` are 00 open, 01 no-access, 10 read-only and 11 open. With relocation on, a read-only zone always gives cause 2'b11 (data storage), and a no-access zone gives it only in user mode.
- R9: With `page_u0` 1 and `u0_exc_en` 1, the result is cause 2'b11. With `u0_exc_en` 0, the U0 attribute has no effect.
- R10: The causes are ranked program, then translation miss, then data storage. Only the highest-ranked cause is reported, and any exception suppresses the invalidation.
- R11: In the cycle after acceptance, `dac_valid` and `dac_store` are 1 and `dac_ea` carries the effective address. `tlb_req` is 1 with `tlb_ea` equal to that address when `reloc_en` is 1.
- R12: The tag compare happens in the cycle after acceptance. `done`, `exc_valid`, `exc_cause` and `inval_hit` are valid for one cycle starting at the next clock edge, and the line state seen on the lookup port changes at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word present |
| instr_word | input | 32 | Instruction word |
| rf_ra_idx | output | 5 | Base register number |
| rf_rb_idx | output | 5 | Index register number |
| rf_ra_data | input | 32 | Base register value |
| rf_rb_data | input | 32 | Index register value |
| user_mode | input | 1 | 1 = user mode, 0 = privileged |
| reloc_en | input | 1 | Data relocation enabled |
| u0_exc_en | input | 1 | Enables the U0-attribute exception |
| tlb_req | output | 1 | Translation lookup request |
| tlb_ea | output | 32 | Address to translate |
| tlb_hit | input | 1 | Valid translation found |
| tlb_zone | input | 2 | Zone protection code of the page |
| page_u0 | input | 1 | User-defined U0 attribute of the page |
| dac_valid | output | 1 | Address offered to debug compare |
| dac_ea | output | 32 | Address for debug compare |
| dac_store | output | 1 | Access is classed as a store |
| fill_en | input | 1 | Install a line |
| fill_line | input | 27 | Line address (address bits [31:5]) to install |
| fill_dirty | input | 1 | Installed line holds modified data |
| probe_line | input | 27 | Line address to look up |
| probe_valid | output | 1 | Looked-up line is present |
| probe_dirty | output | 1 | Looked-up line holds modified data |
| done | output | 1 | Instruction completed |
| exc_valid | output | 1 | Exception raised |
| exc_cause | output | 2 | 01 program, 10 translation miss, 11 data storage |
| inval_hit | output | 1 | A line was invalidated |

## Verification
The invalidation is tried on a clean resident line, on a modified resident line, on an address whose index matches a resident line but whose tag differs, and on an address reached by a carry that wraps past 2^32. Together these separate a true tag match from an index-only match and show that modified data is dropped. The effective address is checked both with a zero base-register field and with a nonzero one, using a nonzero value in register 0, which exposes a base taken from the wrong source. Exception cases combine several causes at once, so a wrong ranking shows up as a wrong cause code. Words that differ from the instruction in a single field show whether each field takes part in the decode.

// File: rtl/inval_pkg.sv
package inval_pkg;

  localparam int XLEN = 32;

  typedef enum logic [1:0] {
    EXC_NONE    = 2'b00,
    EXC_PROGRAM = 2'b01,
    EXC_DTLB    = 2'b10,
    EXC_DSTORE  = 2'b11
  } exc_cause_e;

  typedef enum logic [1:0] {
    ZONE_OPEN   = 2'b00,
    ZONE_NOACC  = 2'b01,
    ZONE_RDONLY = 2'b10,
    ZONE_FULL   = 2'b11
  } zone_e;

  localparam logic [5:0] OPC_PRIMARY = 6'd31;
  localparam logic [9:0] OPC_EXT     = 10'd470;

  // Base is zero when the base-register field is zero
  function automatic logic [XLEN-1:0] eff_addr(
    input logic [4:0]      ra_field,
    input logic [XLEN-1:0] ra_val,
    input logic [XLEN-1:0] rb_val
  );
    logic [XLEN-1:0] base;
    base = (ra_field == 5'd0) ? '0 : ra_val;
    return base + rb_val;
  endfunction

  function automatic logic is_line_inval(input logic [31:0] w);
    return (w[31:26] == OPC_PRIMARY) && (w[25:21] == 5'd0) &&
           (w[10:1] == OPC_EXT) && !w[0];
  endfunction

  // Store-class protection: read-only blocks all, no-access blocks user
  function automatic logic zone_blocks(input logic [1:0] zone, input logic user);
    return (zone == ZONE_RDONLY) || ((zone == ZONE_NOACC) && user);
  endfunction

endpackage

// File: rtl/inval_decode.sv
module inval_decode
  import inval_pkg::*;
(
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] ra_data,
  input  logic [XLEN-1:0] rb_data,
  output logic            is_inval,
  output logic [4:0]      ra_idx,
  output logic [4:0]      rb_idx,
  output logic [XLEN-1:0] ea
);

  assign ra_idx   = instr[20:16];
  assign rb_idx   = instr[15:11];
  assign is_inval = is_line_inval(instr);
  assign ea       = eff_addr(ra_idx, ra_data, rb_data);

endmodule

// File: rtl/inval_guard.sv
module inval_guard
  import inval_pkg::*;
(
  input  logic       user_mode,
  input  logic       reloc_en,
  input  logic       tlb_hit,
  input  logic [1:0] zone,
  input  logic       page_u0,
  input  logic       u0_exc_en,
  output logic       prog_fault,
  output logic       tlb_fault,
  output logic       store_fault,
  output logic [1:0] cause
);

  assign prog_fault  = user_mode;
  assign tlb_fault   = reloc_en && !tlb_hit;
  assign store_fault = (reloc_en && zone_blocks(zone, user_mode)) ||
                       (page_u0 && u0_exc_en);

  always_comb begin
    if (prog_fault)       cause = EXC_PROGRAM;
    else if (tlb_fault)   cause = EXC_DTLB;
    else if (store_fault) cause = EXC_DSTORE;
    else                  cause = EXC_NONE;
  end

endmodule

// File: rtl/inval_tags.sv
module inval_tags #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_dirty,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic [IDX_W-1:0] pr_idx,
  input  logic [TAG_W-1:0] pr_tag,
  output logic             pr_hit,
  output logic             pr_dirty
);

  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] vld_q;
  logic [LINES-1:0] dty_q;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] lk_match;
  logic [LINES-1:0] pr_match;

  // Per-line match vectors; a line matches only when selected and resident
  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign lk_match[g] = vld_q[g] && (lk_idx == IDX_W'(g)) && (tag_q[g] == lk_tag);
    assign pr_match[g] = vld_q[g] && (pr_idx == IDX_W'(g)) && (tag_q[g] == pr_tag);
  end

  assign lk_hit   = |lk_match;
  assign pr_hit   = |pr_match;
  assign pr_dirty = |(pr_match & dty_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      dty_q <= '0;
    end else begin
      if (fill_en) begin
        vld_q[fill_idx] <= 1'b1;
        dty_q[fill_idx] <= fill_dirty;
      end
      if (inv_en) begin
        vld_q[inv_idx] <= 1'b0;
        dty_q[inv_idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx] <= fill_tag;
  end

  AST_INVAL_CLEARS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |=> !vld_q[$past(inv_idx)]) else $error("line still valid"); // R3
  AST_INVAL_DROPS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |=> !dty_q[$past(inv_idx)]) else $error("dirty survived"); // R4
  AST_INVAL_ONLY_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |-> vld_q[inv_idx]) else $error("invalidate of empty line"); // R5

endmodule

// File: rtl/line_inval_unit.sv
module line_inval_unit
  import inval_pkg::*;
#(
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        instr_valid,
  input  logic [31:0] instr_word,
  output logic [4:0]  rf_ra_idx,
  output logic [4:0]  rf_rb_idx,
  input  logic [31:0] rf_ra_data,
  input  logic [31:0] rf_rb_data,
  input  logic        user_mode,
  input  logic        reloc_en,
  input  logic        u0_exc_en,
  output logic        tlb_req,
  output logic [31:0] tlb_ea,
  input  logic        tlb_hit,
  input  logic [1:0]  tlb_zone,
  input  logic        page_u0,
  output logic        dac_valid,
  output logic [31:0] dac_ea,
  output logic        dac_store,
  input  logic        fill_en,
  input  logic [26:0] fill_line,
  input  logic        fill_dirty,
  input  logic [26:0] probe_line,
  output logic        probe_valid,
  output logic        probe_dirty,
  output logic        done,
  output logic        exc_valid,
  output logic [1:0]  exc_cause,
  output logic        inval_hit
);

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = XLEN - OFF_W - IDX_W;
  localparam int LINE_W = XLEN - OFF_W;

  // Decode and address forming (issue cycle)
  logic            dec_ok;
  logic [XLEN-1:0] dec_ea;

  inval_decode u_decode (
    .instr    (instr_word),
    .ra_data  (rf_ra_data),
    .rb_data  (rf_rb_data),
    .is_inval (dec_ok),
    .ra_idx   (rf_ra_idx),
    .rb_idx   (rf_rb_idx),
    .ea       (dec_ea)
  );

  // Check stage registers
  logic            s1_valid;
  logic [XLEN-1:0] s1_ea;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_ea    <= '0;
    end else begin
      s1_valid <= instr_valid && dec_ok;
      if (instr_valid && dec_ok) s1_ea <= dec_ea;
    end
  end

  // Screening (check cycle)
  logic       prog_fault, tlb_fault, store_fault;
  logic [1:0] chk_cause;

  inval_guard u_guard (
    .user_mode   (user_mode),
    .reloc_en    (reloc_en),
    .tlb_hit     (tlb_hit),
    .zone        (tlb_zone),
    .page_u0     (page_u0),
    .u0_exc_en   (u0_exc_en),
    .prog_fault  (prog_fault),
    .tlb_fault   (tlb_fault),
    .store_fault (store_fault),
    .cause       (chk_cause)
  );

  // Tag compare (check cycle) and invalidate at end of it
  logic lk_hit;
  logic inv_fire;

  assign inv_fire = s1_valid && (chk_cause == EXC_NONE) && lk_hit;

  inval_tags #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_en    (fill_en),
    .fill_idx   (fill_line[IDX_W-1:0]),
    .fill_tag   (fill_line[LINE_W-1:IDX_W]),
    .fill_dirty (fill_dirty),
    .lk_idx     (s1_ea[OFF_W+IDX_W-1:OFF_W]),
    .lk_tag     (s1_ea[XLEN-1:OFF_W+IDX_W]),
    .lk_hit     (lk_hit),
    .inv_en     (inv_fire),
    .inv_idx    (s1_ea[OFF_W+IDX_W-1:OFF_W]),
    .pr_idx     (probe_line[IDX_W-1:0]),
    .pr_tag     (probe_line[LINE_W-1:IDX_W]),
    .pr_hit     (probe_valid),
    .pr_dirty   (probe_dirty)
  );

  // Side ports driven in the check cycle
  assign tlb_req   = s1_valid && reloc_en;
  assign tlb_ea    = s1_ea;
  assign dac_valid = s1_valid;
  assign dac_ea    = s1_ea;
  assign dac_store = s1_valid;

  // Completion registers
  logic       done_q;
  logic [1:0] cause_q;
  logic       hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      cause_q <= EXC_NONE;
      hit_q   <= 1'b0;
    end else begin
      done_q  <= s1_valid;
      cause_q <= s1_valid ? chk_cause : EXC_NONE;
      hit_q   <= inv_fire;
    end
  end

  assign done      = done_q;
  assign exc_cause = cause_q;
  assign exc_valid = (cause_q != EXC_NONE);
  assign inval_hit = hit_q;

  AST_DECODE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !dec_ok) |=> !s1_valid) else $error("bad word accepted"); // R1
  AST_DAC_CARRIES_EA: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |-> (dac_ea == $past(dec_ea))) else $error("dac address wrong"); // R11
  AST_MISS_NO_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !lk_hit) |=> (done && !inval_hit)) else $error("miss invalidated"); // R5
  AST_USER_IS_PROGRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && user_mode) |=> (exc_cause == EXC_PROGRAM)) else $error("user not trapped"); // R6
  AST_EXC_BLOCKS_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (done && !inval_hit)) else $error("exception with invalidate"); // R10
  AST_DONE_FOLLOWS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> done) else $error("done missing"); // R12
  AST_DONE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(s1_valid)) else $error("stray done"); // R12

endmodule

// File: tb/tb_line_inval_unit.sv
module tb_line_inval_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic [4:0]  rf_ra_idx, rf_rb_idx;
  logic [31:0] rf_ra_data, rf_rb_data;
  logic        user_mode = 1'b0, reloc_en = 1'b0, u0_exc_en = 1'b0;
  logic        tlb_req;
  logic [31:0] tlb_ea;
  logic        tlb_hit = 1'b1;
  logic [1:0]  tlb_zone = 2'b00;
  logic        page_u0 = 1'b0;
  logic        dac_valid, dac_store;
  logic [31:0] dac_ea;
  logic        fill_en = 1'b0;
  logic [26:0] fill_line = '0;
  logic        fill_dirty = 1'b0;
  logic [26:0] probe_line = '0;
  logic        probe_valid, probe_dirty;
  logic        done, exc_valid, inval_hit;
  logic [1:0]  exc_cause;

  logic [31:0] gpr [32];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  assign rf_ra_data = gpr[rf_ra_idx];
  assign rf_rb_data = gpr[rf_rb_idx];

  always #5 clk = ~clk;

  line_inval_unit dut (.*);

  // observed per instruction
  logic        o_tlbreq, o_dacv, o_dacs, o_done, o_exc, o_hit;
  logic [31:0] o_tlbea, o_dacea;
  logic [1:0]  o_cause;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] ra, input logic [4:0] rb);
    return {6'd31, 5'd0, ra, rb, 10'd470, 1'b0};
  endfunction

  task automatic fill(input logic [31:0] addr, input logic dirty);
    @(negedge clk);
    fill_en = 1'b1; fill_line = addr[31:5]; fill_dirty = dirty;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic probe(input logic [31:0] addr, output logic v, output logic d);
    probe_line = addr[31:5];
    #1;
    v = probe_valid; d = probe_dirty;
  endtask

  // Issue one word; sample check cycle and completion cycle
  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    instr_valid = 1'b1; instr_word = w;
    @(negedge clk);
    instr_valid = 1'b0;
    o_tlbreq = tlb_req; o_tlbea = tlb_ea;
    o_dacv = dac_valid; o_dacea = dac_ea; o_dacs = dac_store;
    @(negedge clk);
    o_done = done; o_exc = exc_valid; o_cause = exc_cause; o_hit = inval_hit;
  endtask

  task automatic set_mode(input logic u, input logic rl, input logic th,
                          input logic [1:0] z, input logic p0, input logic ue);
    user_mode = u; reloc_en = rl; tlb_hit = th; tlb_zone = z; page_u0 = p0; u0_exc_en = ue;
  endtask

  task automatic t_reset;
    logic v, d;
    check("R12 reset done", {31'd0, done}, 32'd0);
    check("R12 reset exc", {31'd0, exc_valid}, 32'd0);
    probe(32'h0, v, d);
    check("R5 reset line empty", {31'd0, v}, 32'd0);
  endtask

  task automatic t_clean_hit;
    logic v, d;
    gpr[3] = 32'h0000_1000; gpr[4] = 32'h0000_0244;
    fill(32'h0000_1240, 1'b0);
    probe(32'h0000_1240, v, d);
    check("R3 line installed", {31'd0, v}, 32'd1);
    set_mode(0, 0, 1, 2'b00, 0, 0);
    issue(mk(5'd3, 5'd4));
    check("R2 ea with base", o_dacea, 32'h0000_1244);
    check("R11 dac store", {30'd0, o_dacv, o_dacs}, 32'd3);
    check("R11 no tlb req when reloc off", {31'd0, o_tlbreq}, 32'd0);
    check("R12 done", {31'd0, o_done}, 32'd1);
    check("R3 inval hit", {31'd0, o_hit}, 32'd1);
    check("R3 no exception", {31'd0, o_exc}, 32'd0);
    probe(32'h0000_1240, v, d);
    check("R3 line gone", {31'd0, v}, 32'd0);
  endtask

  task automatic t_dirty_hit_r0;
    logic v, d;
    gpr[0] = 32'hDEAD_0000; gpr[5] = 32'h0000_2060;
    fill(32'h0000_2060, 1'b1);
    probe(32'h0000_2060, v, d);
    check("R4 installed dirty", {30'd0, v, d}, 32'd3);
    issue(mk(5'd0, 5'd5));
    check("R2 zero base field", o_dacea, 32'h0000_2060);
    check("R4 dirty line hit", {31'd0, o_hit}, 32'd1);
    probe(32'h0000_2060, v, d);
    check("R4 dirty dropped", {30'd0, v, d}, 32'd0);
  endtask

  task automatic t_tag_miss;
    logic v, d;
    // same index as 0x0000_0080, different tag
    fill(32'h0000_0080, 1'b1);
    gpr[6] = 32'h0000_0880; gpr[7] = 32'h0;
    issue(mk(5'd6, 5'd7));
    check("R5 miss done", {31'd0, o_done}, 32'd1);
    check("R5 miss no hit", {31'd0, o_hit}, 32'd0);
    check("R5 miss no exc", {31'd0, o_exc}, 32'd0);
    probe(32'h0000_0080, v, d);
    check("R5 other line intact", {30'd0, v, d}, 32'd3);
  endtask

  task automatic t_wrap;
    logic v, d;
    fill(32'h0000_0020, 1'b0);
    gpr[8] = 32'hFFFF_FFF0; gpr[9] = 32'h0000_0030;
    issue(mk(5'd8, 5'd9));
    check("R2 wrapped ea", o_dacea, 32'h0000_0020);
    probe(32'h0000_0020, v, d);
    check("R3 wrapped line gone", {31'd0, v}, 32'd0);
  endtask

  task automatic t_bad_words;
    logic v, d;
    logic [31:0] w [3];
    gpr[10] = 32'h0000_3000; gpr[11] = 32'h0;
    fill(32'h0000_3000, 1'b0);
    w[0] = mk(5'd10, 5'd11) | 32'h1;
    w[1] = mk(5'd10, 5'd11) ^ (32'd470 << 1) ^ (32'd246 << 1);
    w[2] = mk(5'd10, 5'd11) | (32'd4 << 21);
    for (int i = 0; i < 3; i++) begin
      issue(w[i]);
      check("R1 bad word no dac", {31'd0, o_dacv}, 32'd0);
      check("R1 bad word no done", {31'd0, o_done}, 32'd0);
    end
    probe(32'h0000_3000, v, d);
    check("R1 line untouched", {31'd0, v}, 32'd1);
    issue(mk(5'd10, 5'd11));
    check("R1 good word hits", {31'd0, o_hit}, 32'd1);
  endtask

  task automatic t_exceptions;
    logic v, d;
    gpr[12] = 32'h0000_4000; gpr[13] = 32'h0;
    fill(32'h0000_4000, 1'b1);
    // user + tlb miss + u0: program wins
    set_mode(1, 1, 0, 2'b10, 1, 1);
    issue(mk(5'd12, 5'd13));
    check("R6 program cause", {30'd0, o_cause}, 32'd1);
    check("R10 exc flags", {29'd0, o_done, o_exc, o_hit}, 32'd6);
    // tlb miss beats store faults
    set_mode(0, 1, 0, 2'b10, 1, 1);
    issue(mk(5'd12, 5'd13));
    check("R7 tlb miss cause", {30'd0, o_cause}, 32'd2);
    check("R11 tlb req ea", {o_tlbea[31:1], o_tlbreq}, {32'h0000_4000 | 32'h1});
    check("R10 miss suppresses", {31'd0, o_hit}, 32'd0);
    // read-only zone privileged
    set_mode(0, 1, 1, 2'b10, 0, 0);
    issue(mk(5'd12, 5'd13));
    check("R8 read-only store", {30'd0, o_cause}, 32'd3);
    // u0 enabled, relocation off
    set_mode(0, 0, 0, 2'b10, 1, 1);
    issue(mk(5'd12, 5'd13));
    check("R9 u0 fault", {30'd0, o_cause}, 32'd3);
    probe(32'h0000_4000, v, d);
    check("R10 line survives faults", {30'd0, v, d}, 32'd3);
    // u0 set but disabled, reloc off ignores miss/zone: invalidates
    set_mode(0, 0, 0, 2'b10, 1, 0);
    issue(mk(5'd12, 5'd13));
    check("R9 u0 disabled no exc", {31'd0, o_exc}, 32'd0);
    check("R7 reloc off ignores tlb", {31'd0, o_hit}, 32'd1);
    // no-access zone, privileged, relocation on: allowed
    fill(32'h0000_4000, 1'b0);
    set_mode(0, 1, 1, 2'b01, 0, 0);
    issue(mk(5'd12, 5'd13));
    check("R8 no-access privileged ok", {29'd0, o_done, o_exc, o_hit}, 32'd5);
    set_mode(0, 0, 1, 2'b00, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) gpr[i] = 32'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_clean_hit();
    t_dirty_hit_r0();
    t_tag_miss();
    t_wrap();
    t_bad_words();
    t_exceptions();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule